// File: doc/BRIEF.md
# Flash Bank Mode Tracker

This block follows the operating mode of a single flash bank as decoded bus write events arrive. The mode is one of: plain read, read during a suspended erase, device identification, a command sequence that has started but not finished, an embedded program in progress, or an embedded erase in progress. Upstream logic decodes the unlock cycles into single-cycle event strobes. This block decides what each strobe means in the current mode. A reset command in particular is honoured or ignored depending on the sequence phase, on whether an embedded operation is running, and on whether the bank was suspended.

A one-bit record notes whether the bank sat in erase suspend when a nested sequence began. That record selects the mode to return to after a reset command or after an operation completes. A timeout/error flag taken from the status path is latched for the duration of an embedded operation. While it is latched, a reset command may abort the busy state. Only one event strobe is expected per cycle.

Top module: `bank_mode_tracker`

## Requirements
- R1: While `rst_n` is low, and until two clock edges after it rises, `mode` is 0 (read) and `busy` is 0. A hardware reset also clears the suspend record and the latched error.
- R2: `ev_seq` in read mode (0) moves to the sequence mode (3). `ev_reset` in mode 3, when the sequence began from read, returns to mode 0.
- R3: `ev_reset` in read mode (0) or in erase-suspend-read mode (1) leaves the mode unchanged.
- R4: A sequence begun from mode 1 that is aborted with `ev_reset` returns to mode 1.
- R5: In program-busy mode (4) or erase-busy mode (5), `ev_reset` has no effect while no error has been seen.
- R6: When `err_flag` has been high during the current busy operation, `ev_reset` ends it. Erase-busy returns to mode 0. Program-busy returns to mode 1 if the program was started from suspend, and to mode 0 otherwise.
- R7: `ev_ident` in mode 3 enters identification mode (2). In mode 2 every event other than `ev_reset` is ignored. `ev_reset` returns to mode 1 if the sequence began in suspend, and to mode 0 otherwise.
- R8: `op_done` in mode 5 gives mode 0. `op_done` in mode 4 gives mode 1 for a program started from suspend, and mode 0 otherwise.
- R9: `ev_suspend` in mode 5 gives mode 1. `ev_resume` in mode 1 gives mode 5.
- R10: `busy` is 1 exactly when `mode` is 4 or 5. `ev_prog` in mode 3 gives mode 4, and `ev_erase` in mode 3 (sequence begun from read) gives mode 5.
- R11: The error is remembered after `err_flag` falls and is forgotten when the operation ends or on hardware reset.
- R12: `ev_erase` ending a sequence that began in suspend is rejected, and the bank goes back to mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ev_seq | input | 1 | Non-final command sequence cycle |
| ev_reset | input | 1 | Reset command write |
| ev_erase | input | 1 | Final cycle of an erase sequence |
| ev_prog | input | 1 | Final cycle of a program sequence |
| ev_ident | input | 1 | Final cycle of an identification entry sequence |
| ev_suspend | input | 1 | Erase suspend command |
| ev_resume | input | 1 | Erase resume command |
| op_done | input | 1 | Embedded operation finished |
| err_flag | input | 1 | Timeout/error status of the embedded operation |
| mode | output | 3 | Current mode code (0 read, 1 erase-suspend-read, 2 ident, 3 sequence, 4 program busy, 5 erase busy) |
| busy | output | 1 | Embedded operation in progress |

## Verification
The assertions check every cycle that a reset command without an error leaves a busy mode untouched. They also check that identification mode is left only on a reset command, that an aborted sequence returns to the mode recorded when it began, that completion always ends the busy state, and that the error latch is clear whenever the bank is idle. The choice of return mode depends on earlier history: a program nested in a suspend, an error pulse that has already fallen, a hardware reset clearing a stale error. Only the bench scenarios can show these, because each one drives a full multi-event path.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    BM_READ    = 3'd0,
    BM_SUSP_RD = 3'd1,
    BM_IDENT   = 3'd2,
    BM_SEQ     = 3'd3,
    BM_PGM     = 3'd4,
    BM_ERS     = 3'd5
  } bm_mode_e;

  typedef struct packed {
    logic seq;
    logic rst_cmd;
    logic ers_go;
    logic pgm_go;
    logic ident_go;
    logic susp;
    logic resume;
    logic done;
  } bm_evt_t;
endpackage

// File: rtl/bmt_rst_sync.sv
module bmt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/bmt_err_latch.sv
module bmt_err_latch (
  input  logic clk,
  input  logic rst_ni,
  input  logic busy,
  input  logic err_flag,
  output logic err_seen
);
  logic err_q, err_d, err_en;

  // update only when the state can change
  assign err_en = busy | err_q;

  always_comb begin
    err_d = err_q;
    if (err_en) err_d = busy & (err_q | err_flag);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign err_seen = err_q | (busy & err_flag);

  AST_ERR_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |=> !err_q); // R11
endmodule

// File: rtl/bmt_fsm.sv
module bmt_fsm
  import bmt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_ni,
  input  bm_evt_t  ev,
  input  logic     err_seen,
  output bm_mode_e mode_q,
  output logic     busy
);
  bm_mode_e mode_d, ret_mode;
  logic     rec_q, rec_d;

  assign ret_mode = rec_q ? BM_SUSP_RD : BM_READ;

  always_comb begin
    mode_d = mode_q;
    rec_d  = rec_q;
    unique case (mode_q)
      BM_READ: begin
        if (ev.seq) begin mode_d = BM_SEQ; rec_d = 1'b0; end
      end
      BM_SUSP_RD: begin
        if (ev.seq)         begin mode_d = BM_SEQ; rec_d = 1'b1; end
        else if (ev.resume) begin mode_d = BM_ERS; rec_d = 1'b0; end
      end
      BM_SEQ: begin
        if (ev.rst_cmd)       mode_d = ret_mode;
        else if (ev.ident_go) mode_d = BM_IDENT;
        else if (ev.pgm_go)   mode_d = BM_PGM;
        else if (ev.ers_go)   mode_d = rec_q ? BM_SUSP_RD : BM_ERS;
      end
      BM_IDENT: begin
        if (ev.rst_cmd) mode_d = ret_mode;
      end
      BM_PGM: begin
        if (ev.done || (ev.rst_cmd && err_seen)) mode_d = ret_mode;
      end
      BM_ERS: begin
        if (ev.done || (ev.rst_cmd && err_seen)) mode_d = BM_READ;
        else if (ev.susp) begin mode_d = BM_SUSP_RD; rec_d = 1'b1; end
      end
      default: begin mode_d = BM_READ; rec_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= BM_READ;
      rec_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rec_q  <= rec_d;
    end
  end

  assign busy = (mode_q == BM_PGM) || (mode_q == BM_ERS);

  AST_LOCK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && ev.rst_cmd && !err_seen && !ev.done && !ev.susp |=> mode_q == $past(mode_q)); // R5
  AST_IDENT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == BM_IDENT) && !ev.rst_cmd |=> mode_q == BM_IDENT); // R7
  AST_SEQ_ABORT_RET: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_q == BM_SEQ) && ev.rst_cmd |=> mode_q == ($past(rec_q) ? BM_SUSP_RD : BM_READ)); // R4
  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (!rst_ni)
    busy && ev.done |=> !busy); // R8
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_ni)
    mode_q <= BM_ERS); // R10
endmodule

// File: rtl/bank_mode_tracker.sv
module bank_mode_tracker
  import bmt_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_seq,
  input  logic              ev_reset,
  input  logic              ev_erase,
  input  logic              ev_prog,
  input  logic              ev_ident,
  input  logic              ev_suspend,
  input  logic              ev_resume,
  input  logic              op_done,
  input  logic              err_flag,
  output logic [MODE_W-1:0] mode,
  output logic              busy
);
  logic     rst_sn, err_seen, busy_w;
  bm_evt_t  ev;
  bm_mode_e mode_q;

  assign ev = '{seq: ev_seq, rst_cmd: ev_reset, ers_go: ev_erase, pgm_go: ev_prog,
                ident_go: ev_ident, susp: ev_suspend, resume: ev_resume, done: op_done};

  bmt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_sn)
  );

  bmt_err_latch u_err (
    .clk(clk), .rst_ni(rst_sn), .busy(busy_w), .err_flag(err_flag), .err_seen(err_seen)
  );

  bmt_fsm u_fsm (
    .clk(clk), .rst_ni(rst_sn), .ev(ev), .err_seen(err_seen), .mode_q(mode_q), .busy(busy_w)
  );

  assign mode = mode_q;
  assign busy = busy_w;
endmodule

// File: tb/tb_bank_mode_tracker.sv
module tb_bank_mode_tracker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_seq = 0, ev_reset = 0, ev_erase = 0, ev_prog = 0, ev_ident = 0;
  logic ev_suspend = 0, ev_resume = 0, op_done = 0, err_flag = 0;
  logic [2:0] mode;
  logic busy;
  int checks = 0, errors = 0;
  bit done_run = 0;

  always #5 clk = ~clk;

  bank_mode_tracker dut (
    .clk(clk), .rst_n(rst_n), .ev_seq(ev_seq), .ev_reset(ev_reset), .ev_erase(ev_erase),
    .ev_prog(ev_prog), .ev_ident(ev_ident), .ev_suspend(ev_suspend), .ev_resume(ev_resume),
    .op_done(op_done), .err_flag(err_flag), .mode(mode), .busy(busy)
  );

  localparam int E_SEQ = 0, E_RST = 1, E_ERS = 2, E_PGM = 3, E_ID = 4, E_SUSP = 5,
                 E_RES = 6, E_DONE = 7, E_ERR = 8;

  task automatic pulse(input int e);
    @(negedge clk);
    case (e)
      E_SEQ:  ev_seq = 1;     E_RST: ev_reset = 1;   E_ERS: ev_erase = 1;
      E_PGM:  ev_prog = 1;    E_ID:  ev_ident = 1;   E_SUSP: ev_suspend = 1;
      E_RES:  ev_resume = 1;  E_DONE: op_done = 1;   default: err_flag = 1;
    endcase
    @(negedge clk);
    {ev_seq, ev_reset, ev_erase, ev_prog, ev_ident, ev_suspend, ev_resume, op_done, err_flag} = '0;
  endtask

  task automatic chk(input logic [2:0] exp_mode, input string tag);
    logic exp_busy;
    exp_busy = (exp_mode == 3'd4) || (exp_mode == 3'd5);
    checks++;
    if (mode !== exp_mode || busy !== exp_busy) begin
      errors++;
      $display("FAIL %s mode=%0d busy=%0b expected mode=%0d busy=%0b", tag, mode, busy, exp_mode, exp_busy);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic go_to(input int s);
    hw_reset();
    case (s)
      1: begin pulse(E_SEQ); pulse(E_ERS); pulse(E_SUSP); end
      2: begin pulse(E_SEQ); pulse(E_ID); end
      3: pulse(E_SEQ);
      4: begin pulse(E_SEQ); pulse(E_PGM); end
      5: begin pulse(E_SEQ); pulse(E_ERS); end
      default: ;
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_run) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(3'd0, "R1 during reset");
    rst_n = 1;
    @(negedge clk);
    chk(3'd0, "R1 reset release");

    // reachability of each base mode (R10 busy coding)
    for (int s = 0; s < 6; s++) begin
      go_to(s);
      chk(s[2:0], "R10 mode reach");
    end

    // reset command swept over every base mode without error: R3 R2 R5 R7
    for (int s = 0; s < 6; s++) begin
      logic [2:0] exp;
      go_to(s);
      pulse(E_RST);
      exp = (s >= 4) ? s[2:0] : ((s == 1) ? 3'd1 : 3'd0);
      chk(exp, (s >= 4) ? "R5 reset ignored busy" :
               (s == 2) ? "R7 ident exit" : (s == 3) ? "R2 seq abort" : "R3 reset idle");
    end

    // R4 sequence from suspend aborted
    go_to(1); pulse(E_SEQ); chk(3'd3, "R4 seq from suspend");
    pulse(E_RST); chk(3'd1, "R4 abort to suspend");

    // R7 ident entered from suspend; other events ignored
    go_to(1); pulse(E_SEQ); pulse(E_ID); chk(3'd2, "R7 ident from suspend");
    for (int e = 0; e < 9; e++) if (e != E_RST) pulse(e);
    chk(3'd2, "R7 ident ignores events");
    pulse(E_RST); chk(3'd1, "R7 ident return suspend");

    // R8 completion
    go_to(5); pulse(E_DONE); chk(3'd0, "R8 erase done");
    go_to(4); pulse(E_DONE); chk(3'd0, "R8 program done");
    go_to(1); pulse(E_SEQ); pulse(E_PGM); chk(3'd4, "R10 program in suspend");
    pulse(E_RST); chk(3'd4, "R5 reset ignored nested program");
    pulse(E_DONE); chk(3'd1, "R8 nested program done");

    // R9 suspend/resume
    go_to(1); chk(3'd1, "R9 suspend");
    pulse(E_RES); chk(3'd5, "R9 resume");
    pulse(E_SUSP); chk(3'd1, "R9 second suspend");

    // R6 and R11 error paths
    go_to(5); pulse(E_ERR); pulse(E_SEQ); pulse(E_RST); chk(3'd0, "R11 latched erase error reset");
    go_to(4); pulse(E_ERR); pulse(E_RST); chk(3'd0, "R6 program error reset");
    go_to(1); pulse(E_SEQ); pulse(E_PGM); pulse(E_ERR); pulse(E_RST);
    chk(3'd1, "R6 nested program error reset");
    // R11 error forgotten after completion
    go_to(4); pulse(E_ERR); pulse(E_DONE); pulse(E_SEQ); pulse(E_PGM); pulse(E_RST);
    chk(3'd4, "R11 error cleared by done");
    // R11 hardware reset clears latched error
    go_to(4); pulse(E_ERR); hw_reset(); chk(3'd0, "R1 hw reset mid busy");
    pulse(E_SEQ); pulse(E_PGM); pulse(E_RST); chk(3'd4, "R11 error cleared by hw reset");

    // R12 erase rejected during suspend
    go_to(1); pulse(E_SEQ); pulse(E_ERS); chk(3'd1, "R12 erase in suspend rejected");

    done_run = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule